// File: doc/BRIEF.md
# Spread-Spectrum Filterless PWM Modulator

This block turns a stream of signed digital audio samples into two single-bit drive signals for a speaker connected between them (bridge-tied load). It needs no output filter. With a zero sample, both drive bits go high together at the start of each carrier period and fall together at its midpoint, so the load sees no differential voltage. A nonzero sample lengthens the high time of one drive bit and shortens the other by the same number of ticks. The difference between the two pulse widths is the voltage seen across the load.

The carrier period is counted in system-clock ticks. The nominal value is 256 ticks, which gives about 300 kHz from a 76.8 MHz clock. When the spread control bit is set, every period takes a new length, drawn from a 16-bit maximal-length LFSR, somewhere in the range 197 to 366 ticks. That covers about ±30 % of the carrier frequency. The sample and the spread choice are sampled once per period, at the start of the period. The duty offset is scaled to the period being used, so the modulation depth does not change with the period length. A strobe marks the first tick of every period, so that upstream logic can present the next sample.

Top module: `ss_pwm_mod`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both drive outputs and the period strobe are low. The LFSR is loaded with 16'hACE1.
- R2: With a sample of zero, both outputs are high for the first floor(P/2) ticks of a period of P ticks and low for the rest of it, identical on every tick.
- R3: A sample s (16-bit two's complement) gives an offset d = floor(s*P/65536). The positive output is high for floor(P/2)+d ticks and the negative output for floor(P/2)-d ticks. Each high time starts at the first tick of the period and is contiguous.
- R4: With the spread bit low at the start of a period, the period lasts exactly 256 ticks.
- R5: With the spread bit high at the start of a period, the period is P = 197 + ((L[15:8]*170) >> 8), where L is the LFSR state at that start, so P stays within 197..366. The LFSR steps once at every period start by shifting left and putting bit15^bit13^bit12^bit10 into bit 0.
- R6: The offset is clamped to |d| <= floor(P/2)-1, so each output is high on the first tick and low on the last tick of every period.
- R7: While enable is low, both outputs and the strobe are low and the tick counter is held at zero. The first tick with enable high starts a new period.
- R8: A change of the sample or of the spread bit after a period has started has no effect on that period.
- R9: The period strobe is high on exactly the first tick of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (carrier tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulator enable; low forces the outputs low |
| spread_en | input | 1 | Selects a dithered carrier period instead of the fixed one |
| sample | input | 16 | Signed audio sample, two's complement |
| out_p | output | 1 | Positive drive bit |
| out_n | output | 1 | Negative drive bit |
| period_start | output | 1 | High on the first tick of each carrier period |

## Verification
The modulator is driven with five kinds of input:
- A run of zero samples, which shows that the two outputs stay in phase.
- Random samples that change at random ticks in the middle of a period. These show that the offset is scaled and signed correctly, and that a sample is taken only at the start of a period.
- The full-scale extremes -32768 and +32767, plus a sample of -1. These separate the clamp from the plain offset and show that the offset is floored, not truncated toward zero.
- Spread mode, with period lengths measured from strobe to strobe. This shows that the lengths follow the LFSR sequence, stay inside the allowed range and actually vary.
- Enable dropped partway through a period, and the spread bit switched in the middle of a period. These show that the outputs go quiet and the counter restarts, and that the period chosen at its start is kept to the end.

// File: rtl/ss_pwm_mod.sv
module ss_pwm_mod #(
  parameter int          SW        = 16,
  parameter int          PER_NOM   = 256,
  parameter int          PER_MIN   = 197,
  parameter int          PER_MAX   = 366,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 spread_en,
  input  logic signed [SW-1:0] sample,
  output logic                 out_p,
  output logic                 out_n,
  output logic                 period_start
);

  localparam int CW   = $clog2(PER_MAX + 1);
  localparam int SPAN = PER_MAX - PER_MIN + 1;
  localparam int PW   = SW + CW + 1;
  localparam logic signed [PW-1:0] ONE_W = PW'(1);

  logic [CW-1:0] cnt, per_q, hi_p, hi_n;
  logic          active;
  logic [15:0]   lfsr;
  logic          wrap;

  assign wrap = en && (!active || cnt == per_q - 1'b1);

  // next period length: fixed or LFSR-mapped
  logic [CW+7:0] scaled;
  logic [CW-1:0] spread_per, nxt_per, half;

  assign scaled     = {{CW{1'b0}}, lfsr[15:8]} * (CW+8)'(SPAN);
  assign spread_per = CW'(PER_MIN) + scaled[CW+7:8];
  assign nxt_per    = spread_en ? spread_per : CW'(PER_NOM);
  assign half       = nxt_per >> 1;

  // duty offset scaled to the period, then clamped
  logic signed [PW-1:0] smp_w, per_w, half_w, prod, off_raw, lim_w, off, hp_w, hn_w;

  assign smp_w   = PW'(sample);
  assign per_w   = signed'({{(PW-CW){1'b0}}, nxt_per});
  assign half_w  = signed'({{(PW-CW){1'b0}}, half});
  assign prod    = smp_w * per_w;
  assign off_raw = prod >>> SW;
  assign lim_w   = half_w - ONE_W;
  assign off     = (off_raw > lim_w)  ? lim_w :
                   (off_raw < -lim_w) ? -lim_w : off_raw;
  assign hp_w    = half_w + off;
  assign hn_w    = half_w - off;

  logic lfsr_fb;
  assign lfsr_fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_q  <= CW'(PER_NOM);
      hi_p   <= '0;
      hi_n   <= '0;
      active <= 1'b0;
      lfsr   <= LFSR_SEED;
    end else if (!en) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      active <= 1'b1;
      per_q  <= nxt_per;
      hi_p   <= hp_w[CW-1:0];
      hi_n   <= hn_w[CW-1:0];
      lfsr   <= {lfsr[14:0], lfsr_fb};
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  logic run;
  assign run          = en && active;
  assign out_p        = run && (cnt < hi_p);
  assign out_n        = run && (cnt < hi_n);
  assign period_start = run && (cnt == '0);

  // R7
  en_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0) && !active);

  // R6
  first_tick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> out_p && out_n);

  // R6
  last_tick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == per_q - 1'b1) |-> !out_p && !out_n);

  // R5
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (per_q >= CW'(PER_MIN)) && (per_q <= CW'(PER_MAX)));

  // R4
  fixed_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !spread_en) |=> per_q == CW'(PER_NOM));

  // R8
  mid_period_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(per_q) && $stable(hi_p) && $stable(hi_n));

endmodule

// File: tb/ss_pwm_mod_bench.sv
module ss_pwm_mod_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic spread_en = 1'b0;
  logic signed [15:0] sample = '0;
  logic out_p, out_n, period_start;

  always #2 clk = ~clk;

  ss_pwm_mod u_ss_pwm_mod (
    .clk(clk), .rst_n(rst_n), .en(en), .spread_en(spread_en),
    .sample(sample), .out_p(out_p), .out_n(out_n), .period_start(period_start)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_per, m_hip, m_hin;
  bit m_act;
  logic [15:0] m_lfsr;

  // period length observation
  int len_cnt, len_min, len_max, prev_started;

  function automatic logic [15:0] lfsr_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic int map_per(input logic [15:0] l);
    return 197 + ((int'(l[15:8]) * 170) >> 8);
  endfunction

  function automatic int offset(input int s, input int p);
    longint prod;
    int d, lim;
    prod = longint'(s) * longint'(p);
    d = int'(prod >>> 16);
    lim = p / 2 - 1;
    if (d > lim) d = lim;
    if (d < -lim) d = -lim;
    return d;
  endfunction

  task automatic check(input string req, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: advance the model with the inputs in force at the edge, compare
  task automatic step(input string req, input bit meas_spread);
    int d;
    bit ep, en_, ps;
    @(negedge clk);
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_lfsr = 16'hACE1;
    end else if (!en) begin
      m_act = 0; m_cnt = 0;
    end else if (!m_act || m_cnt == m_per - 1) begin
      m_act = 1; m_cnt = 0;
      m_per = spread_en ? map_per(m_lfsr) : 256;
      m_lfsr = lfsr_next(m_lfsr);
      d = offset(int'(sample), m_per);
      m_hip = m_per / 2 + d;
      m_hin = m_per / 2 - d;
    end else begin
      m_cnt++;
    end
    ep = en && m_act && rst_n && (m_cnt < m_hip);
    en_ = en && m_act && rst_n && (m_cnt < m_hin);
    ps = en && m_act && rst_n && (m_cnt == 0);
    check(req, {out_p, out_n, period_start} == {ep, en_, ps}, "outputs {p,n,start}",
          int'({out_p, out_n, period_start}), int'({ep, en_, ps}));
    len_cnt++;
    if (!en) prev_started = 0;
    if (period_start) begin
      if (meas_spread && prev_started) begin
        check("R5", len_cnt >= 197 && len_cnt <= 366, "spread period length", len_cnt, 197);
        if (len_cnt < len_min) len_min = len_cnt;
        if (len_cnt > len_max) len_max = len_cnt;
      end
      prev_started = 1;
      len_cnt = 0;
    end
  endtask

  task automatic run(input string req, input int n, input bit rnd, input bit meas);
    for (int i = 0; i < n; i++) begin
      step(req, meas);
      if (rnd && ($urandom % 64) == 0) sample = 16'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_act = 0; m_cnt = 0; m_per = 256; m_hip = 0; m_hin = 0; m_lfsr = 16'hACE1;
    len_cnt = 0; len_min = 1000; len_max = 0; prev_started = 0;

    // R1: reset state
    run("R1", 4, 0, 0);
    rst_n = 1'b1;
    run("R1", 3, 0, 0);

    // R2 R9: zero input, fixed period
    en = 1'b1;
    run("R2", 4 * 256, 0, 0);

    // R3 R8: random samples changing mid-period
    sample = 16'($urandom);
    run("R8", 20 * 256, 1, 0);

    // R3: small negative value floors
    sample = -16'sd1;
    run("R3", 2 * 256, 0, 0);

    // R6: extremes clamp
    sample = 16'sh7FFF;
    run("R6", 2 * 256, 0, 0);
    sample = 16'sh8000;
    run("R6", 2 * 256, 0, 0);

    // R5: spread mode with random samples
    spread_en = 1'b1;
    sample = 16'($urandom);
    run("R5", 60 * 280, 1, 1);
    check("R5", len_max > len_min, "spread lengths vary (max)", len_max, len_min + 1);

    // R7: enable dropped mid-period, then restored
    run("R7", 57, 1, 0);
    en = 1'b0;
    sample = 16'sh7FFF;
    run("R7", 20, 0, 0);
    en = 1'b1;
    run("R9", 3 * 280, 0, 0);

    // R4 R8: spread bit cleared mid-period only affects next period
    spread_en = 1'b0;
    sample = 16'sd1000;
    run("R4", 6 * 300, 1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule